// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block computes one iteration of a 32-bit non-restoring division each time it is strobed. It keeps three status bits between iterations: Q (the running quotient-sign bit), M (the divisor-sign bit) and T (the bit that carries a quotient digit out to the surrounding datapath). The partial dividend and the divisor come in as operands. The updated partial dividend is registered on the next clock edge.

A surrounding datapath first issues a setup strobe. The signed setup takes Q and M from the operand sign bits. The unsigned setup clears all three status bits. The datapath then chains steps. Between steps it rotates the low dividend word through T, using the T-write strobe, so that dividend bits feed in and quotient bits come out. The block does not sequence the iterations, decode instructions or correct the final quotient.

Top module: `divstep_unit`

## Requirements
- R1: A synchronous reset clears partOut, qBit, mBit and tBit to 0.
- R2: An unsigned setup strobe clears qBit, mBit and tBit on the next edge.
- R3: A signed setup strobe loads qBit from partIn bit 31 and mBit from divisor bit 31, and sets tBit to their XOR.
- R4: A step shifts partIn left by one bit and fills bit 0 with the current tBit.
- R5: A step subtracts the divisor from the shifted value when the stored Q equals M, and adds it otherwise. The 32-bit outcome appears on partOut after the edge.
- R6: After a step, qBit equals partIn bit 31 XOR mBit XOR the carry or borrow out of the 32-bit add or subtract.
- R7: After a step, tBit is 1 exactly when the new qBit equals mBit. mBit is unchanged by a step.
- R8: A T-write strobe loads tBit from tValue and leaves qBit, mBit and partOut unchanged.
- R9: When strobes coincide, the priority is unsigned setup, then signed setup, then step, then T-write. A strobe that loses has no effect.
- R10: With no strobe asserted, partOut, qBit, mBit and tBit hold, whatever the operand inputs do.
- R11: Thirty-two unsigned steps, each preceded by a rotate of the low dividend word through T, give the exact unsigned quotient of a 32-bit dividend by a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Perform one division step |
| setupSigned | input | 1 | Load Q and M from operand signs |
| setupUnsigned | input | 1 | Clear Q, M and T |
| tWrite | input | 1 | Load T from tValue |
| tValue | input | 1 | Value written into T |
| divisor | input | 32 | Divisor operand |
| partIn | input | 32 | Current partial dividend |
| partOut | output | 32 | Registered partial dividend after the last step |
| qBit | output | 1 | Stored Q status bit |
| mBit | output | 1 | Stored M status bit |
| tBit | output | 1 | Stored T status bit |

## Verification
The hardest states to reach are the step cases where the stored Q differs from M and T holds an arbitrary value. This matters most for the add path with a carry out. The stimulus reaches these states by combining signed setups on random sign pairs with independent T writes before each random step. Every step outcome is compared with a bench model written from the requirements. Long chains of 32 rotate-and-step pairs are checked against integer division. These chains cover the corner divisors 1 and 0x80000000, a divisor above the dividend, and all-ones operands.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  // One-hot strobes from the control decoder to the datapath
  typedef struct packed {
    logic clearAll;
    logic loadSigns;
    logic doStep;
    logic writeT;
  } ctrlStrobe_t;
endpackage

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
  import divstep_pkg::*;
(
  input  logic        stepEn,
  input  logic        setupSigned,
  input  logic        setupUnsigned,
  input  logic        tWrite,
  output ctrlStrobe_t strobes
);
  // Fixed priority: unsigned setup, signed setup, step, T write
  always_comb begin
    strobes = '0;
    if (setupUnsigned)    strobes.clearAll  = 1'b1;
    else if (setupSigned) strobes.loadSigns = 1'b1;
    else if (stepEn)      strobes.doStep    = 1'b1;
    else if (tWrite)      strobes.writeT    = 1'b1;
  end
endmodule

// File: rtl/divstep_datapath.sv
module divstep_datapath
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobes,
  input  logic             tValue,
  input  logic [WIDTH-1:0] divisor,
  input  logic [WIDTH-1:0] partIn,
  output logic [WIDTH-1:0] partOut,
  output logic             qBit,
  output logic             mBit,
  output logic             tBit
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted;
  logic [WIDTH:0]   extSum;
  logic             subMode;
  logic             carryOut;
  logic             qNext;

  assign shifted  = {partIn[MSB-1:0], tBit};
  assign subMode  = (qBit == mBit);
  assign extSum   = subMode ? ({1'b0, shifted} - {1'b0, divisor})
                            : ({1'b0, shifted} + {1'b0, divisor});
  assign carryOut = extSum[WIDTH];
  assign qNext    = partIn[MSB] ^ mBit ^ carryOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      partOut <= '0;
      qBit    <= 1'b0;
      mBit    <= 1'b0;
      tBit    <= 1'b0;
    end else if (strobes.clearAll) begin
      qBit <= 1'b0;
      mBit <= 1'b0;
      tBit <= 1'b0;
    end else if (strobes.loadSigns) begin
      qBit <= partIn[MSB];
      mBit <= divisor[MSB];
      tBit <= partIn[MSB] ^ divisor[MSB];
    end else if (strobes.doStep) begin
      partOut <= extSum[MSB:0];
      qBit    <= qNext;
      tBit    <= (qNext == mBit);
    end else if (strobes.writeT) begin
      tBit <= tValue;
    end
  end
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  input  logic             setupSigned,
  input  logic             setupUnsigned,
  input  logic             tWrite,
  input  logic             tValue,
  input  logic [WIDTH-1:0] divisor,
  input  logic [WIDTH-1:0] partIn,
  output logic [WIDTH-1:0] partOut,
  output logic             qBit,
  output logic             mBit,
  output logic             tBit
);
  ctrlStrobe_t strobes;

  divstep_ctrl ctrl_i (
    .stepEn(stepEn), .setupSigned(setupSigned), .setupUnsigned(setupUnsigned),
    .tWrite(tWrite), .strobes(strobes)
  );

  divstep_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .tValue(tValue),
    .divisor(divisor), .partIn(partIn), .partOut(partOut),
    .qBit(qBit), .mBit(mBit), .tBit(tBit)
  );
endmodule

// File: rtl/divstep_checker.sv
module divstep_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             stepEn,
  input logic             setupSigned,
  input logic             setupUnsigned,
  input logic             tWrite,
  input logic             tValue,
  input logic             divisorMsb,
  input logic             partInMsb,
  input logic [WIDTH-1:0] partOut,
  input logic             qBit,
  input logic             mBit,
  input logic             tBit
);
  AST_UNSIGNED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    setupUnsigned |=> (!qBit && !mBit && !tBit)); // R2

  AST_SIGNED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (setupSigned && !setupUnsigned) |=>
      (qBit == $past(partInMsb) && mBit == $past(divisorMsb) && tBit == (qBit ^ mBit))); // R3

  AST_STEP_T_MATCH: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !setupSigned && !setupUnsigned) |=> (tBit == (qBit == mBit))); // R7

  AST_STEP_M_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !setupSigned && !setupUnsigned) |=> $stable(mBit)); // R7

  AST_TWRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (tWrite && !stepEn && !setupSigned && !setupUnsigned) |=>
      (tBit == $past(tValue) && $stable(qBit) && $stable(mBit) && $stable(partOut))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tWrite && !stepEn && !setupSigned && !setupUnsigned) |=>
      ($stable(partOut) && $stable(qBit) && $stable(mBit) && $stable(tBit))); // R10

  AST_RESULT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (setupSigned || setupUnsigned) |=> $stable(partOut)); // R9
endmodule

bind divstep_unit divstep_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .stepEn(stepEn), .setupSigned(setupSigned),
  .setupUnsigned(setupUnsigned), .tWrite(tWrite), .tValue(tValue),
  .divisorMsb(divisor[WIDTH-1]), .partInMsb(partIn[WIDTH-1]),
  .partOut(partOut), .qBit(qBit), .mBit(mBit), .tBit(tBit)
);

// File: tb/divstep_unit_tb_top.sv
module divstep_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepEn = 1'b0, setupSigned = 1'b0, setupUnsigned = 1'b0;
  logic tWrite = 1'b0, tValue = 1'b0;
  logic [W-1:0] divisor = '0, partIn = '0;
  logic [W-1:0] partOut;
  logic qBit, mBit, tBit;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divstep_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .stepEn(stepEn), .setupSigned(setupSigned),
    .setupUnsigned(setupUnsigned), .tWrite(tWrite), .tValue(tValue),
    .divisor(divisor), .partIn(partIn), .partOut(partOut),
    .qBit(qBit), .mBit(mBit), .tBit(tBit)
  );

  // Reference step: returns {q, t, result}
  function automatic logic [W+1:0] stepRef(input logic [W-1:0] pd, input logic [W-1:0] dv,
                                           input logic q, input logic m, input logic t);
    logic [W-1:0] sh;
    logic [W:0]   r;
    logic         nq;
    sh = {pd[W-2:0], t};
    if (q == m) r = {1'b0, sh} - {1'b0, dv};
    else        r = {1'b0, sh} + {1'b0, dv};
    nq = pd[W-1] ^ m ^ r[W];
    return {nq, (nq == m), r[W-1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive strobes after a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic pulse(input bit s, input bit ss, input bit su, input bit tw, input bit tv,
                       input logic [W-1:0] dv, input logic [W-1:0] pd);
    stepEn = s; setupSigned = ss; setupUnsigned = su; tWrite = tw; tValue = tv;
    divisor = dv; partIn = pd;
    @(posedge clk);
    @(negedge clk);
    stepEn = 0; setupSigned = 0; setupUnsigned = 0; tWrite = 0;
  endtask

  task automatic randomStep();
    logic [W-1:0] dv, pd;
    logic [W+1:0] e;
    logic q0, m0, t0;
    dv = $urandom(); pd = $urandom();
    pulse(0, 1, 0, 0, 0, {$urandom_range(0,1) == 1, 31'h0}, {$urandom_range(0,1) == 1, 31'h0});
    pulse(0, 0, 0, 1, $urandom_range(0,1) == 1, '0, '0);
    q0 = qBit; m0 = mBit; t0 = tBit;
    e = stepRef(pd, dv, q0, m0, t0);
    pulse(1, 0, 0, 0, 0, dv, pd);
    check(partOut == e[W-1:0], "R4/R5 step result", partOut, e[W-1:0]);
    check(qBit == e[W+1], "R6 step Q", qBit, e[W+1]);
    check(tBit == e[W] && mBit == m0, "R7 step T and M", {mBit, tBit}, {m0, e[W]});
  endtask

  task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] pd, r2, quo;
    logic tRot;
    pulse(0, 0, 1, 0, 0, '0, '0);
    pd = '0; r2 = a;
    for (int i = 0; i < W; i++) begin
      tRot = r2[W-1];
      r2 = {r2[W-2:0], tBit};
      pulse(0, 0, 0, 1, tRot, '0, '0);
      pulse(1, 0, 0, 0, 0, b, pd);
      pd = partOut;
    end
    quo = {r2[W-2:0], tBit};
    check(quo == a / b, "R11 chained quotient", quo, a / b);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check(partOut == 0 && qBit == 0 && mBit == 0 && tBit == 0, "R1 reset state",
          {partOut, qBit, mBit, tBit}, 0);
    rst = 0;

    // R3 signed setup on all sign pairs
    for (int k = 0; k < 4; k++) begin
      pulse(0, 1, 0, 0, 0, {k[1], 31'h1234}, {k[0], 31'h55});
      check(qBit == k[0] && mBit == k[1] && tBit == (k[0] ^ k[1]), "R3 signed setup",
            {qBit, mBit, tBit}, {k[0], k[1], k[0] ^ k[1]});
    end
    // R2 unsigned setup clears
    pulse(0, 1, 0, 0, 0, 32'h8000_0000, 32'h0);
    pulse(0, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(!qBit && !mBit && !tBit, "R2 unsigned setup", {qBit, mBit, tBit}, 0);

    // R8 T write
    pulse(0, 0, 0, 1, 1, '0, '0);
    check(tBit && !qBit && !mBit && partOut == 0, "R8 T write", {partOut, qBit, mBit, tBit}, 1);

    // R9 both setups: unsigned wins
    pulse(0, 1, 1, 0, 0, 32'h8000_0000, 32'h8000_0000);
    check(!qBit && !mBit && !tBit, "R9 unsigned over signed", {qBit, mBit, tBit}, 0);
    // R9 signed over step: result untouched
    pulse(1, 1, 0, 0, 0, 32'h8000_0001, 32'h7000_0000);
    check(partOut == 0 && !qBit && mBit && tBit, "R9 signed over step", {partOut, qBit, mBit, tBit}, 3);
    // R9 step over T write: Q=0 M=1 T=1, pd=1, dv=1 -> add: sh=3, r=4, no carry, q=0^1^0=1, t=1
    pulse(1, 0, 0, 1, 0, 32'h1, 32'h1);
    check(partOut == 4 && qBit && tBit, "R9 step over T write", {partOut, qBit, tBit}, {32'h4, 2'b11});

    // R10 idle hold with moving inputs
    divisor = 32'hDEAD_BEEF; partIn = 32'hFFFF_FFFF; tValue = 0;
    repeat (3) @(negedge clk);
    check(partOut == 4 && qBit && mBit && tBit, "R10 hold", {partOut, qBit, mBit, tBit}, {32'h4, 3'b111});

    // R5/R6 directed: unsigned, subtract with borrow; pd=0, dv=5 -> r=FFFFFFFB, q=1, t=0
    pulse(0, 0, 1, 0, 0, '0, '0);
    pulse(1, 0, 0, 0, 0, 32'h5, 32'h0);
    check(partOut == 32'hFFFF_FFFB && qBit && !tBit, "R5 R6 subtract borrow",
          {partOut, qBit, tBit}, {32'hFFFF_FFFB, 2'b10});

    for (int n = 0; n < 60; n++) randomStep();

    divide(32'd100, 32'd7);
    divide(32'h0, 32'd3);
    divide(32'hFFFF_FFFF, 32'h1);
    divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    divide(32'd5, 32'd9);
    divide(32'hFFFF_FFFF, 32'h8000_0000);
    for (int n = 0; n < 30; n++) begin
      logic [W-1:0] b;
      b = $urandom() >> $urandom_range(0, 31);
      if (b == 0) b = 1;
      divide($urandom(), b);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule